// File: doc/BRIEF.md
# Debug-Safe Two-Step Status Flag Bank

This block holds a small bank of peripheral status flags. A hardware event strobe sets each flag. Software clears a flag in two steps. It first reads the shared status register while the flag is 1, which arms that flag. It then reads or writes the data register that belongs to that flag, which completes the clear. Reading the status register returns the current flags at once.

A debug-break level input protects the flags. While break is active and the clear-enable bit is 0, no bus access can clear a flag, and a status read does not arm a flag. An arm taken before break began is kept through the break, so the second step after break exit still completes the clear. With the clear-enable bit set, the normal two-step clear works during break, and a flag cleared that way stays cleared after break ends.

Top module: `sflag_bank`

## Requirements
- R1: While `rst_ni` is low, all flags and all arm latches are 0, and `flag_o` reads 0.
- R2: A 1 on `set_i[k]` at a clock edge makes `flag_o[k]` 1 from that edge onward.
- R3: A read (`bus_rd_i`=1) at address 0 drives `rd_data_o` in the same cycle, with bit k equal to flag k. Any other cycle gives `rd_data_o`=0.
- R4: Clearing is allowed when break is inactive or the clear-enable bit is 1. A status read with flag k at 1 arms flag k. A later read or write at address 1+k, with clearing allowed, makes `flag_o[k]` 0 at that edge.
- R5: An access at address 1+k without a prior arm has no effect. A status read while flag k is 0 does not arm flag k.
- R6: While `brk_i`=1 and `brk_clr_en_i`=0, no flag goes from 1 to 0, and an existing arm is kept.
- R7: While `brk_i`=1 and `brk_clr_en_i`=1, the two-step clear of R4 works as normal.
- R8: A flag cleared during break stays 0 after `brk_i` falls.
- R9: An arm taken before break survives break, whatever accesses are blocked during it. The second step after break exit clears the flag.
- R10: A set event in the same cycle as a completing second step wins. The flag stays 1 and its arm is dropped.
- R11: A set event on an armed flag drops the arm. A fresh status read is needed before the flag can be cleared.
- R12: A status read during protected break (`brk_i`=1, `brk_clr_en_i`=0) arms nothing.
- R13: An access at address 1+k never changes any flag other than k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | NUM_FLAGS | Per-flag set event strobes |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Register select: 0 status, 1+k data register of flag k |
| brk_i | input | 1 | Debug break active level |
| brk_clr_en_i | input | 1 | Allows clearing while break is active |
| flag_o | output | NUM_FLAGS | Current flag values |
| rd_data_o | output | NUM_FLAGS | Status read data |

## Verification
A set event and a completing second step can land on the same flag in the same cycle. A status read can also coincide with a set event on other bits. The bench drives these cases directly: a set strobe on an armed flag together with its data-register access. It then follows with a lone second step to confirm that the arm was dropped. A random phase toggles break, enable, strobes and addresses each cycle. A behavioural model judges every clock, so each ordering of arm, break entry, break exit and second step is compared edge by edge.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SET   = 2'd1,
    CELL_CLEAR = 2'd2,
    CELL_ARM   = 2'd3
  } cell_act_e;
endpackage

// File: rtl/sflag_decode.sv
module sflag_decode #(
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned DATA_BASE = 1
) (
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  output logic                 stat_rd_o,
  output logic [NUM_FLAGS-1:0] step2_o
);
  logic acc;
  assign acc       = bus_rd_i | bus_wr_i;
  assign stat_rd_o = bus_rd_i && (bus_addr_i == ADDR_W'(STAT_ADDR));

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_dat
    localparam int unsigned DADDR = DATA_BASE + k;
    assign step2_o[k] = acc && (bus_addr_i == ADDR_W'(DADDR));
  end
endmodule

// File: rtl/sflag_cell.sv
module sflag_cell
  import sflag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic step2_i,
  input  logic clr_ok_i,
  output logic flag_o,
  output logic arm_o
);
  logic      flag_q, arm_q;
  cell_act_e act;

  // set beats clear; arming needs the flag high and clearing allowed
  always_comb begin
    act = CELL_HOLD;
    if (set_i)                             act = CELL_SET;
    else if (arm_q && step2_i && clr_ok_i) act = CELL_CLEAR;
    else if (stat_rd_i && clr_ok_i && flag_q) act = CELL_ARM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      unique case (act)
        CELL_SET:   begin flag_q <= 1'b1; arm_q <= 1'b0; end
        CELL_CLEAR: begin flag_q <= 1'b0; arm_q <= 1'b0; end
        CELL_ARM:   arm_q <= 1'b1;
        default:    ;
      endcase
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/sflag_rdmux.sv
module sflag_rdmux #(
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic                 stat_rd_i,
  input  logic [NUM_FLAGS-1:0] flag_i,
  output logic [NUM_FLAGS-1:0] rd_data_o
);
  assign rd_data_o = stat_rd_i ? flag_i : '0;
endmodule

// File: rtl/sflag_bank.sv
module sflag_bank #(
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned DATA_BASE = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 bus_rd_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 brk_i,
  input  logic                 brk_clr_en_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic [NUM_FLAGS-1:0] rd_data_o
);
  logic                 stat_rd;
  logic                 clr_ok;
  logic [NUM_FLAGS-1:0] step2;
  logic [NUM_FLAGS-1:0] arm_q;

  assign clr_ok = !brk_i || brk_clr_en_i;

  sflag_decode #(
    .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .bus_rd_i  (bus_rd_i),
    .bus_wr_i  (bus_wr_i),
    .bus_addr_i(bus_addr_i),
    .stat_rd_o (stat_rd),
    .step2_o   (step2)
  );

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_cell
    sflag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_i[k]),
      .stat_rd_i(stat_rd),
      .step2_i  (step2[k]),
      .clr_ok_i (clr_ok),
      .flag_o   (flag_o[k]),
      .arm_o    (arm_q[k])
    );
  end

  sflag_rdmux #(.NUM_FLAGS(NUM_FLAGS)) u_rd (
    .stat_rd_i(stat_rd),
    .flag_i   (flag_o),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/sflag_bank_chk.sv
module sflag_bank_chk #(
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned DATA_BASE = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_FLAGS-1:0] set_i,
  input logic                 bus_rd_i,
  input logic                 bus_wr_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic                 brk_i,
  input logic                 brk_clr_en_i,
  input logic [NUM_FLAGS-1:0] flag_o,
  input logic [NUM_FLAGS-1:0] rd_data_o,
  input logic [NUM_FLAGS-1:0] arm_q
);
  assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  assert_rd_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_i && bus_addr_i == ADDR_W'(STAT_ADDR)) |-> (rd_data_o == '0));

  assert_no_clear_protected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !brk_clr_en_i) |=> ((~flag_o & $past(flag_o)) == '0));

  assert_no_arm_protected_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !brk_clr_en_i) |=> ((arm_q & ~$past(arm_q)) == '0));

  assert_arm_implies_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((arm_q & ~flag_o) == '0));

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_fall
    localparam int unsigned DADDR = DATA_BASE + k;
    // R13: a flag only falls after an access to its own data register
    assert_fall_own_addr_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[k]) |-> $past((bus_rd_i || bus_wr_i) && bus_addr_i == ADDR_W'(DADDR)));
  end
endmodule

bind sflag_bank sflag_bank_chk #(
  .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W),
  .STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
  .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .brk_i(brk_i), .brk_clr_en_i(brk_clr_en_i),
  .flag_o(flag_o), .rd_data_o(rd_data_o), .arm_q(arm_q)
);

// File: tb/sim_sflag_bank.sv
`timescale 1ns/100ps
module sim_sflag_bank;
  localparam int N = 4;
  localparam int AW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  set_i = '0;
  logic          bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic          brk_i = 1'b0, brk_clr_en_i = 1'b0;
  logic [N-1:0]  flag_o, rd_data_o;

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [N-1:0] mf = '0, ma = '0;

  always #2.5 clk_i = ~clk_i;

  sflag_bank #(.NUM_FLAGS(N), .ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .brk_i(brk_i), .brk_clr_en_i(brk_clr_en_i),
    .flag_o(flag_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference: one edge of behaviour from current inputs
  task automatic model_step();
    logic ok;
    logic [N-1:0] nf, na;
    ok = !brk_i || brk_clr_en_i;
    nf = mf; na = ma;
    for (int k = 0; k < N; k++) begin
      bit s2;
      s2 = (bus_rd_i || bus_wr_i) && (int'(bus_addr_i) == k + 1);
      if (set_i[k]) begin nf[k] = 1; na[k] = 0; end
      else if (ma[k] && s2 && ok) begin nf[k] = 0; na[k] = 0; end
      else if (bus_rd_i && bus_addr_i == 0 && ok && mf[k]) na[k] = 1;
    end
    mf = nf; ma = na;
  endtask

  task automatic tick();
    logic [N-1:0] erd;
    #1;
    erd = (bus_rd_i && bus_addr_i == 0) ? mf : '0;
    chk({cur_req, " rd_data"}, 32'(rd_data_o), 32'(erd));
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    set_i = '0; bus_rd_i = 0; bus_wr_i = 0; bus_addr_i = '0;
    chk({cur_req, " flags"}, 32'(flag_o), 32'(mf));
  endtask

  task automatic acc(input bit rd, input bit wr, input int a);
    bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = AW'(a);
    tick();
  endtask

  task automatic setp(input logic [N-1:0] m);
    set_i = m;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset flags", 32'(flag_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 32'(flag_o), 0);

    cur_req = "R2"; setp(4'b0101);
    chk("R2 set", 32'(flag_o), 32'h5);

    cur_req = "R3"; acc(1, 0, 0);
    acc(1, 0, 5); acc(0, 1, 0);

    cur_req = "R4"; acc(1, 0, 0); acc(1, 0, 1);
    chk("R4 read clears f0", 32'(flag_o), 32'h4);
    cur_req = "R13";
    chk("R13 f2 untouched", 32'(flag_o[2]), 1);
    cur_req = "R4"; acc(1, 0, 0); acc(0, 1, 3);
    chk("R4 write clears f2", 32'(flag_o), 32'h0);

    cur_req = "R5"; acc(0, 1, 2); setp(4'b0010); acc(1, 0, 2);
    chk("R5 unarmed step2", 32'(flag_o[1]), 1);
    acc(1, 0, 0); setp(4'b1000); acc(0, 1, 4);
    chk("R5 no arm on zero", 32'(flag_o[3]), 1);

    cur_req = "R6"; acc(1, 0, 0);
    brk_i = 1; acc(1, 0, 2); acc(0, 1, 4);
    chk("R6 protected", 32'(flag_o), 32'ha);
    cur_req = "R9"; brk_i = 0; acc(0, 1, 2);
    chk("R9 clear after exit", 32'(flag_o), 32'h8);
    acc(1, 0, 0); brk_i = 1; tick(); brk_i = 0; acc(0, 1, 4);
    chk("R9 arm through quiet break", 32'(flag_o), 32'h0);

    cur_req = "R12"; setp(4'b0001); brk_i = 1; acc(1, 0, 0);
    brk_i = 0; acc(1, 0, 1);
    chk("R12 no arm in break", 32'(flag_o[0]), 1);

    cur_req = "R7"; brk_i = 1; brk_clr_en_i = 1; acc(1, 0, 0); acc(0, 1, 1);
    chk("R7 clear in break", 32'(flag_o[0]), 0);
    cur_req = "R8"; brk_i = 0; brk_clr_en_i = 0; tick(); tick();
    chk("R8 stays clear", 32'(flag_o[0]), 0);

    cur_req = "R10"; setp(4'b1000); acc(1, 0, 0);
    set_i = 4'b1000; acc(1, 0, 4);
    chk("R10 set wins", 32'(flag_o[3]), 1);
    acc(0, 1, 4);
    chk("R10 arm dropped", 32'(flag_o[3]), 1);

    cur_req = "R11"; acc(1, 0, 0); setp(4'b1000); acc(0, 1, 4);
    chk("R11 re-set drops arm", 32'(flag_o[3]), 1);
    acc(1, 0, 0); acc(0, 1, 4);
    chk("R11 fresh read clears", 32'(flag_o[3]), 0);

    cur_req = "R13";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) brk_i = ~brk_i;
      if (r == 1) brk_clr_en_i = ~brk_clr_en_i;
      set_i = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      bus_rd_i = $urandom_range(0, 1) == 1;
      bus_wr_i = !bus_rd_i && ($urandom_range(0, 2) == 0);
      bus_addr_i = AW'($urandom_range(0, 5));
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule